// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Suspend

This block gathers a set of block indices to be erased and then runs the erase one block at a time. Each incoming select pulse marks one block in an internal selection mask and restarts a collection window. The window is timed by an external tick strobe. When a full window passes with no new selection, the list is frozen and the scheduler issues one erase request per block. Blocks that are selected but protected are skipped. The physical erase is carried out elsewhere and reports back through a done/fail handshake.

A suspend pulse pauses the work. Its effect depends on the phase. During the collection window it freezes the list at once, and the matching resume starts erasing straight away, with no further wait. During erasing it withdraws the current request, and resume asks for the same block again. The status outputs show whether the block is busy, suspended, past the window, or stopped on an error.

Top module: `erase_sched`

## Requirements
- R1: After reset `busy`, `suspended`, `timer_started`, `error` and `er_req` are all low.
- R2: A `sel_valid` pulse while idle sets bit `sel_idx` (a binary block number) of the selection mask. It raises `busy` and keeps `timer_started` low.
- R3: The window closes on the WIN_TICKS-th `tick` after the most recent selection, and `timer_started` then rises. Each further `sel_valid` inside the window adds its block and restarts the count from zero.
- R4: Once the window has closed, `sel_valid` is ignored until the scheduler is idle again. A block selected then is never requested.
- R5: Erase requests go out one at a time, from the lowest selected index to the highest. `er_req` stays high with `er_idx` (binary block number) steady until `er_done` or `er_fail`. The next pending block is requested in the cycle after `er_done`.
- R6: A selected block whose `prot_mask` bit is 1 is never requested, and skipping it raises no error.
- R7: If every selected block is protected, no request is issued. `busy` and `timer_started` stay high for EMPTY_TICKS ticks and then drop.
- R8: A `suspend` pulse during the window raises `suspended` and lowers `busy` at once, and ticks are no longer counted. A `resume` pulse then starts erasing in the next cycle. Selections made while suspended or after the resume are ignored.
- R9: A `suspend` pulse during erasing withdraws `er_req` and raises `suspended`. `resume` asks again for the interrupted block. This may be repeated any number of times.
- R10: After `er_done` for the last pending block, `busy`, `timer_started` and `er_req` are low and the selection mask is empty.
- R11: `er_fail` raises `error`. The output stays high, with `busy` and `er_req` low, ignoring all inputs until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe |
| sel_valid | input | 1 | Block-select pulse |
| sel_idx | input | IW | Block number carried by the select |
| suspend | input | 1 | Suspend pulse |
| resume | input | 1 | Resume pulse |
| prot_mask | input | NBLK | Per-block protection, 1 = protected |
| er_req | output | 1 | Erase request for one block |
| er_idx | output | IW | Block number being requested |
| er_done | input | 1 | Current block erased |
| er_fail | input | 1 | Current block failed |
| busy | output | 1 | Window open, erasing, or empty wait |
| suspended | output | 1 | Work paused |
| timer_started | output | 1 | Window has closed |
| error | output | 1 | Failure latched |

## Verification
Most internal faults become visible at the ports almost immediately. A wrong selection mask shows up as a missing, extra or out-of-order `er_idx` as soon as the window closes. A wrong window count moves the rise of `timer_started` and the first request by whole ticks. A lost resume position shows as a different block being requested one cycle after `resume`. A state that leaks out of the error or suspended phase shows as `busy` or `er_req` rising within one cycle of an ignored stimulus.

// File: rtl/erase_sched.sv
module erase_sched #(
  parameter int NBLK        = 8,
  parameter int WIN_TICKS   = 50,
  parameter int EMPTY_TICKS = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    sel_valid,
  input  logic [$clog2(NBLK)-1:0] sel_idx,
  input  logic                    suspend,
  input  logic                    resume,
  input  logic [NBLK-1:0]         prot_mask,
  output logic                    er_req,
  output logic [$clog2(NBLK)-1:0] er_idx,
  input  logic                    er_done,
  input  logic                    er_fail,
  output logic                    busy,
  output logic                    suspended,
  output logic                    timer_started,
  output logic                    error
);
  localparam int IW   = $clog2(NBLK);
  localparam int MAXT = (WIN_TICKS > EMPTY_TICKS) ? WIN_TICKS : EMPTY_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_RUN, S_SUSP, S_EMPTY, S_ERR} st_t;

  st_t             st;
  logic [NBLK-1:0] sel_m;
  logic [CW-1:0]   cnt;
  logic            started;

  wire [NBLK-1:0] pend = sel_m & ~prot_mask;
  wire            have = |pend;
  wire st_t       close_to = have ? S_RUN : S_EMPTY;

  logic [IW-1:0] cur;
  always_comb begin
    cur = '0;
    for (int i = NBLK - 1; i >= 0; i--)
      if (pend[i]) cur = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sel_m   <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (sel_valid) begin
          sel_m[sel_idx] <= 1'b1;
          cnt            <= '0;
          st             <= S_WIN;
        end
        S_WIN: begin
          if (suspend) st <= S_SUSP;
          else if (sel_valid) begin
            sel_m[sel_idx] <= 1'b1;
            cnt            <= '0;
          end else if (tick) begin
            if (cnt == CW'(WIN_TICKS - 1)) begin
              st      <= close_to;
              started <= 1'b1;
              cnt     <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_RUN: begin
          if (!have) begin
            st      <= S_IDLE;
            sel_m   <= '0;
            started <= 1'b0;
          end else if (er_fail) st <= S_ERR;
          else if (er_done) begin
            sel_m[cur] <= 1'b0;
            if (pend == (NBLK'(1) << cur)) begin
              st      <= S_IDLE;
              sel_m   <= '0;
              started <= 1'b0;
            end
          end else if (suspend) st <= S_SUSP;
        end
        S_SUSP: if (resume) begin
          st      <= close_to;
          started <= 1'b1;
          cnt     <= '0;
        end
        S_EMPTY: if (tick) begin
          if (cnt == CW'(EMPTY_TICKS - 1)) begin
            st      <= S_IDLE;
            sel_m   <= '0;
            started <= 1'b0;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign er_req        = (st == S_RUN) && have;
  assign er_idx        = cur;
  assign busy          = (st == S_WIN) || (st == S_RUN) || (st == S_EMPTY);
  assign suspended     = (st == S_SUSP);
  assign timer_started = started;
  assign error         = (st == S_ERR);
endmodule

module erase_sched_chk #(
  parameter int NBLK = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    er_req,
  input logic [$clog2(NBLK)-1:0] er_idx,
  input logic                    er_done,
  input logic                    er_fail,
  input logic                    suspend,
  input logic [NBLK-1:0]         prot_mask,
  input logic                    busy,
  input logic                    suspended,
  input logic                    error
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_req && !er_done && !er_fail && !suspend |=> er_req && $stable(er_idx));
  // R5
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_req |-> busy);
  // R6
  prot_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_req |-> !prot_mask[er_idx]);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !er_req && !busy);
  // R9
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !busy && !er_req);
endmodule

bind erase_sched erase_sched_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .er_req(er_req), .er_idx(er_idx),
  .er_done(er_done), .er_fail(er_fail), .suspend(suspend),
  .prot_mask(prot_mask), .busy(busy), .suspended(suspended), .error(error)
);

// File: tb/erase_sched_bench.sv
module erase_sched_bench;
  localparam int PER   = 10;
  localparam int NB    = 4;
  localparam int WIN   = 3;
  localparam int EMPTY = 4;

  logic clk = 0, rst_n = 0, tick = 0, sel_valid = 0, suspend = 0, resume = 0;
  logic er_done = 0, er_fail = 0;
  logic [1:0] sel_idx = 0;
  logic [NB-1:0] prot_mask = 0;
  logic er_req, busy, suspended, timer_started, error;
  logic [1:0] er_idx;
  int nchk = 0, nbad = 0;

  always #(PER/2) clk = ~clk;

  erase_sched #(.NBLK(NB), .WIN_TICKS(WIN), .EMPTY_TICKS(EMPTY)) u_erase_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .suspend(suspend), .resume(resume), .prot_mask(prot_mask), .er_req(er_req),
    .er_idx(er_idx), .er_done(er_done), .er_fail(er_fail), .busy(busy),
    .suspended(suspended), .timer_started(timer_started), .error(error));

  task automatic chk(input int act, input int exp, input string r);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic p_sel(input int i);
    sel_valid = 1; sel_idx = 2'(i); cyc(); sel_valid = 0;
  endtask
  task automatic p_tick(); tick = 1; cyc(); tick = 0; endtask
  task automatic p_done(); er_done = 1; cyc(); er_done = 0; endtask
  task automatic p_susp(); suspend = 1; cyc(); suspend = 0; endtask
  task automatic p_res(); resume = 1; cyc(); resume = 0; endtask
  task automatic p_fail(); er_fail = 1; cyc(); er_fail = 0; endtask

  task automatic req_is(input int idx, input string r);
    chk(er_req, 1, r);
    chk(er_idx, idx, r);
  endtask

  task automatic idle_is(input string r);
    chk(busy, 0, r); chk(er_req, 0, r); chk(timer_started, 0, r);
  endtask

  initial begin
    #(PER*150000);
    nbad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1
    chk(busy, 0, "R1"); chk(suspended, 0, "R1"); chk(timer_started, 0, "R1");
    chk(error, 0, "R1"); chk(er_req, 0, "R1");

    // sweep over every selection and protection mask
    for (int s = 1; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        prot_mask = 4'(p);
        cyc();
        for (int i = 0; i < NB; i++) if (s[i]) p_sel(i);
        chk(busy, 1, "R2"); chk(timer_started, 0, "R2");
        for (int t = 0; t < WIN - 1; t++) p_tick();
        chk(timer_started, 0, "R3"); chk(er_req, 0, "R3");
        p_tick();
        chk(timer_started, 1, "R3");
        if ((s & ~p & 15) == 0) begin
          chk(er_req, 0, "R7"); chk(busy, 1, "R7");
          for (int t = 0; t < EMPTY - 1; t++) p_tick();
          chk(busy, 1, "R7"); chk(er_req, 0, "R7");
          p_tick();
          idle_is("R7");
        end else begin
          for (int i = 0; i < NB; i++) if (s[i] && !p[i]) begin
            req_is(i, "R5 R6");
            p_done();
          end
          idle_is("R10");
          chk(error, 0, "R6");
        end
      end
    end
    prot_mask = 0;

    // retrigger and late selection
    p_sel(1); p_tick(); p_tick();
    p_sel(2); p_tick(); p_tick();
    chk(timer_started, 0, "R3");
    p_tick();
    req_is(1, "R3");
    p_sel(0);
    req_is(1, "R4");
    p_done();
    req_is(2, "R4");
    p_done();
    idle_is("R4");

    // suspend inside the window
    p_sel(3); p_susp();
    chk(suspended, 1, "R8"); chk(busy, 0, "R8");
    for (int t = 0; t < 5; t++) p_tick();
    chk(suspended, 1, "R8"); chk(er_req, 0, "R8");
    p_sel(0);
    p_res();
    req_is(3, "R8"); chk(timer_started, 1, "R8");
    p_sel(0);
    p_done();
    idle_is("R8");

    // suspend during erasing, repeated
    p_sel(0); p_sel(2);
    for (int t = 0; t < WIN; t++) p_tick();
    req_is(0, "R9");
    p_done();
    req_is(2, "R9");
    p_susp();
    chk(er_req, 0, "R9"); chk(suspended, 1, "R9");
    p_sel(1);
    p_res();
    req_is(2, "R9");
    p_susp(); p_res();
    req_is(2, "R9");
    p_done();
    idle_is("R9");

    // failure is sticky
    p_sel(1);
    for (int t = 0; t < WIN; t++) p_tick();
    req_is(1, "R11");
    p_fail();
    chk(error, 1, "R11"); chk(busy, 0, "R11"); chk(er_req, 0, "R11");
    p_sel(0);
    for (int t = 0; t < WIN + 1; t++) p_tick();
    p_res();
    chk(error, 1, "R11"); chk(er_req, 0, "R11"); chk(busy, 0, "R11");
    rst_n = 0; cyc(); rst_n = 1; cyc();
    chk(error, 0, "R11"); idle_is("R1");

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule